// File: doc/BRIEF.md
# SPI Word Buffer and Event Controller

This block sits between a simple register bus and a serial shift engine. Software writes outgoing words into a transmit queue, and the engine pops them one at a time. The engine pushes the words it receives into a receive queue, and software drains that queue by reading a data register. Each queue holds eight 32-bit words. One control word sets both queue thresholds and can flush either queue or both.

Three event flags are kept: transmit done, receive level reached, and receive overrun. Each flag latches no matter what its enable bit says. Software clears a flag by writing a one to it. The single interrupt line is a registered OR of the enabled flags. A live receive-ready bit is shown next to the flags so that software can tell a stale level event from a current one. The serial timing is outside this block.

Top module: `spfi_ctrl`

## Requirements
- R1: The transmit queue holds up to 8 words in first-in first-out order. A bus write to address 1 pushes `reg_wdata`. The push is dropped when the queue already holds 8 words at that clock. `eng_tx_pop` removes the head when the queue is not empty. `eng_tx_valid` shows that the queue is not empty. `eng_tx_data` is the head word, or 0 when the queue is empty.
- R2: The receive queue holds up to 8 words. `eng_rx_push` appends `eng_rx_data` when the queue is not full. Reading address 2 returns the head word, and the head is removed when `reg_re` is high. When the queue is empty the read returns 0 and nothing changes.
- R3: The control register is at address 0. Bit 0 flushes the transmit queue and bit 1 flushes the receive queue. Bits [7:4] hold the transmit threshold and bits [11:8] hold the receive threshold. A flush takes priority over a push or pop in the same cycle. A read returns the thresholds in the same bit positions, with the flush bits read as 0.
- R4: The status register at address 3 reads bit 0 = 1 while the receive queue is not empty, and 0 in all other bits.
- R5: Address 5 bit 3 is the live receive-ready bit. It is 1 when the receive threshold is not zero and the receive occupancy is at least the threshold.
- R6: The receive-level flag (address 5 bit 1) sets one cycle after the receive-ready condition holds.
- R7: The overrun flag (address 5 bit 2) sets one cycle after `eng_rx_push` arrives while the receive queue holds 8 words. That word is discarded.
- R8: The transmit-done flag (address 5 bit 0) sets one cycle after a cycle in which the transmit queue is empty and `eng_idle` is high.
- R9: Writing address 6 clears each flag whose bit in `reg_wdata[2:0]` is 1. If the set condition holds in the same cycle, the set wins.
- R10: The enable register at address 4, bits [2:0], uses the same bit order as the flags and reads back. Flags latch whatever the enable value is.
- R11: `irq` equals the OR of (flags AND enables) as it was one cycle earlier.
- R12: After reset both queues are empty, the thresholds, enables and flags are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Bus write strobe |
| reg_re | input | 1 | Bus read strobe (pops the receive queue at address 2) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | 32 | Transmit head word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_idle | input | 1 | Engine has no shift in progress |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions run on every cycle. They check that queue occupancy never exceeds the depth and that a push into a full transmit queue leaves it full. They also check that an empty receive read returns zero, that a double flush empties both queues, that an overrun push latches its flag, that the status bit follows receive occupancy, and that the interrupt line is the registered OR of the enabled flags. Some behaviour can only be shown by the bench scenarios, which replay traffic against a queue-based reference model on every clock. That includes the first-in first-out order of the data, dropped words that never show up later, the set-over-clear priority, the threshold level events, and the flush-versus-push priority.

// File: rtl/spfi_pkg.sv
package spfi_pkg;
   // register addresses
   localparam int A_CTRL  = 0;
   localparam int A_TXDAT = 1;
   localparam int A_RXDAT = 2;
   localparam int A_STAT  = 3;
   localparam int A_IEN   = 4;
   localparam int A_ISTAT = 5;
   localparam int A_ICLR  = 6;
   // control word fields
   localparam int CTL_TXFL   = 0;
   localparam int CTL_RXFL   = 1;
   localparam int CTL_TXTH_L = 4;
   localparam int CTL_RXTH_L = 8;
   // event indices
   typedef enum int {
      EV_TXDONE = 0,
      EV_RXLVL  = 1,
      EV_OVR    = 2
   } ev_idx_e;
   localparam int NUM_EV    = 3;
   localparam int ISTAT_RAW = 3;
endpackage

// File: rtl/spfi_fifo.sv
module spfi_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/spfi_evt.sv
module spfi_evt #(
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic            en_wr,
   input  logic [NSRC-1:0] en_d,
   output logic [NSRC-1:0] flags_o,
   output logic [NSRC-1:0] en_o,
   output logic            irq_o
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) flags_o[i] <= 1'b0;
         else        flags_o[i] <= (flags_o[i] & ~clr_i[i]) | set_i[i];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)     en_o[i] <= 1'b0;
         else if (en_wr) en_o[i] <= en_d[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(flags_o & en_o);
   end
endmodule

// File: rtl/spfi_ctrl.sv
module spfi_ctrl
   import spfi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int THR_W  = 4,
   parameter int ADDR_W = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              eng_tx_pop,
   output logic [DATA_W-1:0] eng_tx_data,
   output logic              eng_tx_valid,
   input  logic              eng_rx_push,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              eng_idle,
   output logic              irq
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spfi_ctrl: DEPTH must be a power of two >= 2");
   end
   if (DEPTH >= (1 << THR_W)) begin : g_bad_thr
      $error("spfi_ctrl: THR_W too narrow for DEPTH");
   end
   if (DATA_W < CTL_RXTH_L + THR_W) begin : g_bad_width
      $error("spfi_ctrl: DATA_W too narrow for control word");
   end

   logic              ctrl_wr, tx_wr, rx_rd, ien_wr, iclr_wr;
   logic [THR_W-1:0]  tx_thr, rx_thr;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [DATA_W-1:0] rx_head;
   logic              rx_raw;
   logic [NUM_EV-1:0] ev_set, ev_clr, irq_flags, irq_en;

   assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(A_CTRL));
   assign tx_wr   = reg_we && (reg_addr == ADDR_W'(A_TXDAT));
   assign rx_rd   = reg_re && (reg_addr == ADDR_W'(A_RXDAT));
   assign ien_wr  = reg_we && (reg_addr == ADDR_W'(A_IEN));
   assign iclr_wr = reg_we && (reg_addr == ADDR_W'(A_ICLR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_thr <= '0;
         rx_thr <= '0;
      end else if (ctrl_wr) begin
         tx_thr <= reg_wdata[CTL_TXTH_L +: THR_W];
         rx_thr <= reg_wdata[CTL_RXTH_L +: THR_W];
      end
   end

   spfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (ctrl_wr && reg_wdata[CTL_TXFL]),
      .push      (tx_wr),
      .push_data (reg_wdata),
      .pop       (eng_tx_pop),
      .head      (eng_tx_data),
      .count     (tx_cnt),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   spfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (ctrl_wr && reg_wdata[CTL_RXFL]),
      .push      (eng_rx_push),
      .push_data (eng_rx_data),
      .pop       (rx_rd),
      .head      (rx_head),
      .count     (rx_cnt),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   assign eng_tx_valid = !tx_empty;
   assign rx_raw = (rx_thr != '0) && (int'(rx_cnt) >= int'(rx_thr));

   always_comb begin
      ev_set            = '0;
      ev_set[EV_TXDONE] = tx_empty && eng_idle;
      ev_set[EV_RXLVL]  = rx_raw;
      ev_set[EV_OVR]    = eng_rx_push && rx_full;
      ev_clr            = iclr_wr ? reg_wdata[NUM_EV-1:0] : '0;
   end

   spfi_evt #(.NSRC(NUM_EV)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev_set),
      .clr_i   (ev_clr),
      .en_wr   (ien_wr),
      .en_d    (reg_wdata[NUM_EV-1:0]),
      .flags_o (irq_flags),
      .en_o    (irq_en),
      .irq_o   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         A_CTRL: begin
            reg_rdata[CTL_TXTH_L +: THR_W] = tx_thr;
            reg_rdata[CTL_RXTH_L +: THR_W] = rx_thr;
         end
         A_RXDAT: reg_rdata = rx_head;
         A_STAT:  reg_rdata[0] = !rx_empty;
         A_IEN:   reg_rdata[NUM_EV-1:0] = irq_en;
         A_ISTAT: begin
            reg_rdata[NUM_EV-1:0] = irq_flags;
            reg_rdata[ISTAT_RAW]  = rx_raw;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spfi_ctrl_chk.sv
module spfi_ctrl_chk
   import spfi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic              reg_re,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              eng_tx_pop,
   input logic              eng_rx_push,
   input logic [CNT_W-1:0]  tx_cnt,
   input logic [CNT_W-1:0]  rx_cnt,
   input logic [NUM_EV-1:0] irq_flags,
   input logic [NUM_EV-1:0] irq_en,
   input logic              irq
);
   AST_TX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      int'(tx_cnt) <= DEPTH && int'(rx_cnt) <= DEPTH); // R1

   AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_TXDAT) && int'(tx_cnt) == DEPTH && !eng_tx_pop)
      |=> int'(tx_cnt) == DEPTH); // R1

   AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == '0 && reg_addr == ADDR_W'(A_RXDAT)) |-> reg_rdata == '0); // R2

   AST_FLUSH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[CTL_TXFL] && reg_wdata[CTL_RXFL])
      |=> (tx_cnt == '0 && rx_cnt == '0)); // R3

   AST_STAT_RNE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(A_STAT)) |-> reg_rdata[0] == (rx_cnt != '0)); // R4

   AST_OVR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && int'(rx_cnt) == DEPTH) |=> irq_flags[EV_OVR]); // R7

   AST_IRQ_REG: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(irq_flags & irq_en))); // R11
endmodule

bind spfi_ctrl spfi_ctrl_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/sim_spfi_ctrl.sv
module sim_spfi_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [31:0] eng_tx_data;
   logic        eng_tx_valid;
   logic        eng_rx_push = 1'b0;
   logic [31:0] eng_rx_data = '0;
   logic        eng_idle = 1'b0;
   logic        irq;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spfi_ctrl u0 (.*);

   // reference model
   logic [31:0] txq[$], rxq[$];
   logic [3:0]  m_ttx, m_trx;
   logic [2:0]  m_fl, m_en, m_set, m_clr;
   logic        m_irq, m_raw;
   int          ntx, nrx;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_ttx = 0; m_trx = 0; m_fl = 0; m_en = 0; m_irq = 0;
      end else begin
         ntx = txq.size(); nrx = rxq.size();
         m_raw = (m_trx != 0) && (nrx >= int'(m_trx));
         m_irq = |(m_fl & m_en);
         m_set = {eng_rx_push && nrx == 8, m_raw, ntx == 0 && eng_idle};
         m_clr = (reg_we && reg_addr == 6) ? reg_wdata[2:0] : 3'b0;
         m_fl  = (m_fl & ~m_clr) | m_set;
         if (reg_we && reg_addr == 4) m_en = reg_wdata[2:0];
         if (eng_tx_pop && ntx > 0) void'(txq.pop_front());
         if (reg_we && reg_addr == 1 && ntx < 8) txq.push_back(reg_wdata);
         if (reg_re && reg_addr == 2 && nrx > 0) void'(rxq.pop_front());
         if (eng_rx_push && nrx < 8) rxq.push_back(eng_rx_data);
         if (reg_we && reg_addr == 0) begin
            if (reg_wdata[0]) txq.delete();
            if (reg_wdata[1]) rxq.delete();
            m_ttx = reg_wdata[7:4];
            m_trx = reg_wdata[11:8];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rdata();
      logic [31:0] v = '0;
      case (int'(reg_addr))
         0: begin v[7:4] = m_ttx; v[11:8] = m_trx; end
         2: v = (rxq.size() > 0) ? rxq[0] : 32'h0;
         3: v[0] = rxq.size() != 0;
         4: v[2:0] = m_en;
         5: begin
            v[2:0] = m_fl;
            v[3] = (m_trx != 0) && (rxq.size() >= int'(m_trx));
         end
         default: v = '0;
      endcase
      return v;
   endfunction

   // compare every cycle, away from the edge
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R11 irq", {31'b0, irq}, {31'b0, m_irq});
         chk("R1 tx_valid", {31'b0, eng_tx_valid}, {31'b0, txq.size() != 0});
         chk("R1 tx_data", eng_tx_data, (txq.size() > 0) ? txq[0] : 32'h0);
         case (int'(reg_addr))
            0: chk("R3 ctrl", reg_rdata, exp_rdata());
            2: chk("R2 rxdata", reg_rdata, exp_rdata());
            3: chk("R4 status", reg_rdata, exp_rdata());
            4: chk("R10 enable", reg_rdata, exp_rdata());
            5: chk("R5 R6 R7 R8 R9 istat", reg_rdata, exp_rdata());
            default: chk("R3 other", reg_rdata, exp_rdata());
         endcase
      end
   end

   task automatic step(input logic we, input logic re, input int addr, input logic [31:0] wd,
                       input logic txpop, input logic rxpush, input logic [31:0] rxd,
                       input logic idle);
      @(negedge clk);
      reg_we = we; reg_re = re; reg_addr = 4'(addr); reg_wdata = wd;
      eng_tx_pop = txpop; eng_rx_push = rxpush; eng_rx_data = rxd; eng_idle = idle;
   endtask

   task automatic idle_n(input int n, input int addr);
      for (int i = 0; i < n; i++) step(0, 0, addr, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R12 reset state
      chk("R12 irq", {31'b0, irq}, 32'h0);
      chk("R12 tx_valid", {31'b0, eng_tx_valid}, 32'h0);
      chk("R12 ctrl", reg_rdata, 32'h0);
      // enable all events, thresholds 4/4
      step(1, 0, 4, 32'h7, 0, 0, 0, 0);
      step(1, 0, 0, 32'h0000_0440, 0, 0, 0, 0);
      step(1, 0, 6, 32'h7, 0, 0, 0, 0);
      idle_n(2, 5);
      // R1: nine pushes, last one dropped
      for (int i = 0; i < 9; i++) step(1, 0, 1, 32'hA000_0000 + i, 0, 0, 0, 0);
      // drain with the engine, then idle -> R8
      for (int i = 0; i < 9; i++) step(0, 0, 5, 0, 1, 0, 0, 0);
      idle_n(1, 5);
      step(0, 0, 5, 0, 0, 0, 0, 1);
      idle_n(3, 5);
      // R9: clear while condition persists (set wins), then clear when gone
      step(1, 0, 6, 32'h1, 0, 0, 0, 1);
      step(1, 0, 6, 32'h1, 0, 0, 0, 0);
      idle_n(2, 5);
      // R2 R5 R6: four receive words reach threshold
      for (int i = 0; i < 4; i++) step(0, 0, 3, 0, 0, 1, 32'hB000_0000 + i, 0);
      idle_n(2, 5);
      step(1, 0, 6, 32'h2, 0, 0, 0, 0);
      // R2 read two words
      for (int i = 0; i < 2; i++) step(0, 1, 2, 0, 0, 0, 0, 0);
      idle_n(1, 5);
      step(1, 0, 6, 32'h2, 0, 0, 0, 0);
      idle_n(2, 5);
      // R7 overrun: fill and push two more
      for (int i = 0; i < 8; i++) step(0, 0, 5, 0, 0, 1, 32'hC000_0000 + i, 0);
      idle_n(2, 5);
      // R2 drain everything, plus two reads of an empty queue
      for (int i = 0; i < 10; i++) step(0, 1, 2, 0, 0, 0, 0, 0);
      idle_n(1, 3);
      // R10: disable all, clear, then create an overrun while masked
      step(1, 0, 4, 32'h0, 0, 0, 0, 0);
      step(1, 0, 6, 32'h7, 0, 0, 0, 0);
      for (int i = 0; i < 9; i++) step(0, 0, 5, 0, 0, 1, 32'hD000_0000 + i, 0);
      idle_n(3, 5);
      step(1, 0, 4, 32'h4, 0, 0, 0, 0);
      idle_n(3, 4);
      // R3: flush both with same-cycle pushes
      step(1, 0, 1, 32'h1234, 0, 0, 0, 0);
      step(1, 0, 0, 32'h0000_0823, 0, 1, 32'hEEEE, 0);
      idle_n(2, 0);
      step(0, 0, 2, 0, 0, 0, 0, 0);
      step(0, 0, 3, 0, 0, 0, 0, 0);
      // flush only tx while rx keeps data
      step(1, 0, 1, 32'h55, 0, 1, 32'h66, 0);
      step(1, 0, 0, 32'h0000_0231, 0, 0, 0, 0);
      idle_n(2, 2);
      step(0, 1, 2, 0, 0, 0, 0, 0);
      idle_n(3, 5);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 5000);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<5000 cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule